// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out the program counter that follows a control-transfer instruction in a small 8-bit processor core. It handles three kinds of instruction. Conditional branches test one status-register bit against an expected polarity. A relative jump is always taken. Skips test either whether two register bytes are equal or the state of one bit of a register byte. For each instruction it reports the next PC, whether the branch or skip was taken, and how many cycles the instruction costs.

The decoder presents one instruction per cycle with `valid_i` high. It supplies the current PC, the status byte, an operation class, a bit index and an expected polarity, a signed offset, and two operand bytes. It also supplies a flag that says whether the instruction after this one is two words long. The results are registered and appear one clock later with `valid_o` high. While `valid_i` is low, the result registers keep their last values.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `next_pc_o`, `taken_o` and `cycles_o` are all zero.
- R2: A result appears on the clock edge after the one that samples `valid_i` high, and `valid_o` is high with it. After an edge that samples `valid_i` low, `valid_o` is low and `next_pc_o`, `taken_o` and `cycles_o` keep their previous values.
- R3: Operation class 0 is a flag branch. It is taken when bit `sel_i` of `sreg_i` equals `pol_i`. The status bits from bit 7 down to bit 0 are I, T, H, S, V, N, Z, C. Each named branch is therefore one bit and one polarity: equal is Z=1, lower is C=1, minus is N=1, signed less-than is S=1, overflow is V=1, interrupt-enabled is I=1 and T-set is T=1. Each complementary branch tests the same bit for 0.
- R4: A taken flag branch gives `pc_i + sext(offset_i[6:0]) + 1` and 2 cycles. Bits 11 to 7 of `offset_i` have no effect on a flag branch.
- R5: A flag branch that is not taken gives `pc_i + 1`, `taken_o` low and 1 cycle.
- R6: Operation class 1 is a relative jump. It always gives `pc_i + sext(offset_i[11:0]) + 1`, with `taken_o` high and 2 cycles.
- R7: Operation class 2 skips when `opa_i` equals `opb_i`.
- R8: Operation class 3 skips when bit `sel_i` of `opa_i` equals `pol_i`. A polarity of 0 means skip if the bit is clear. A polarity of 1 means skip if the bit is set.
- R9: A skip over a one-word instruction (`two_word_i`=0) gives `pc_i + 2` and 2 cycles. A skip over a two-word instruction gives `pc_i + 3` and 3 cycles. When no skip happens the result is `pc_i + 1`, `taken_o` low and 1 cycle, whatever `two_word_i` is.
- R10: All PC arithmetic wraps modulo 2^16.
- R11: Operation classes 4 to 7 are not control transfers. They give `pc_i + 1`, `taken_o` low and 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Operation class: 0 flag branch, 1 relative jump, 2 skip if equal, 3 skip on bit |
| pc_i | input | 16 | PC of the current instruction |
| sreg_i | input | 8 | Status byte {I,T,H,S,V,N,Z,C} |
| sel_i | input | 3 | Status bit or operand bit index |
| pol_i | input | 1 | Expected bit value for a taken branch or skip |
| offset_i | input | 12 | Signed offset; a flag branch uses the low 7 bits, a jump uses all 12 |
| opa_i | input | 8 | First register operand |
| opb_i | input | 8 | Second register operand |
| two_word_i | input | 1 | The following instruction is two words long |
| valid_o | output | 1 | Result valid |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch or jump taken, or skip performed |
| cycles_o | output | 2 | Instruction cycle count |

## Verification
Every result is due exactly one clock edge after the edge that samples the instruction, because all outputs come from one register stage. The bench drives its inputs on a falling edge, lets one rising edge pass, and compares on the next falling edge. At that point the outputs are settled and no input has changed yet. The hold behaviour is checked the same way. The bench drops `valid_i` with different operands, lets one edge pass, and confirms that the previous result has not moved. The reset case is sampled while reset is still held.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned PC_W      = 16;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BR_OFF_W  = 7;
  localparam int unsigned JMP_OFF_W = 12;
  localparam int unsigned OP_W      = 3;
  localparam int unsigned CYC_W     = 2;
  localparam int unsigned SEL_W     = $clog2(DATA_W);

  typedef enum logic [OP_W-1:0] {
    OP_FLAG_BR = 3'd0,
    OP_REL_JMP = 3'd1,
    OP_SKIP_EQ = 3'd2,
    OP_SKIP_BIT = 3'd3
  } op_e;

  // status byte bit positions
  localparam int unsigned SR_C = 0;
  localparam int unsigned SR_Z = 1;
  localparam int unsigned SR_N = 2;
  localparam int unsigned SR_V = 3;
  localparam int unsigned SR_S = 4;
  localparam int unsigned SR_H = 5;
  localparam int unsigned SR_T = 6;
  localparam int unsigned SR_I = 7;

  typedef struct packed {
    logic [PC_W-1:0]  npc;
    logic             taken;
    logic [CYC_W-1:0] cycles;
  } npc_res_t;
endpackage

// File: rtl/npc_bit_test.sv
module npc_bit_test #(
  parameter int unsigned W     = 8,
  localparam int unsigned SW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] sel_i,
  input  logic          pol_i,
  output logic          hit_o
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < int'(W); i++) begin
      if (sel_i == SW'(i)) picked = data_i[i];
    end
    hit_o = ~(picked ^ pol_i);
  end
endmodule

// File: rtl/npc_rel_adder.sv
module npc_rel_adder #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  tgt_o
);
  logic [PC_W-1:0] off_ext;

  generate
    if (OFF_W < PC_W) begin : g_extend
      assign off_ext = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext = off_i[PC_W-1:0];
    end
  endgenerate

  // wraps modulo 2^PC_W
  assign tgt_o = pc_i + off_ext + PC_W'(1);
endmodule

// File: rtl/npc_skip_eval.sv
module npc_skip_eval #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CYC_W  = 2,
  localparam int unsigned SW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic              bit_mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [SW-1:0]     sel_i,
  input  logic              pol_i,
  input  logic              two_word_i,
  output logic              skip_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [CYC_W-1:0]  cycles_o
);
  logic eq_hit;
  logic bit_hit;
  logic [CYC_W-1:0] step;

  assign eq_hit = (opa_i == opb_i);

  npc_bit_test #(.W(DATA_W)) u_bit (
    .data_i (opa_i),
    .sel_i  (sel_i),
    .pol_i  (pol_i),
    .hit_o  (bit_hit)
  );

  assign skip_o = bit_mode_i ? bit_hit : eq_hit;

  // step equals cycle count: 1 no skip, 2 over one word, 3 over two
  always_comb begin
    if (!skip_o)         step = CYC_W'(1);
    else if (two_word_i) step = CYC_W'(3);
    else                 step = CYC_W'(2);
  end

  assign cycles_o = step;
  assign npc_o    = pc_i + PC_W'(step);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic [DATA_W-1:0]    sreg_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 pol_i,
  input  logic [JMP_OFF_W-1:0] offset_i,
  input  logic [DATA_W-1:0]    opa_i,
  input  logic [DATA_W-1:0]    opb_i,
  input  logic                 two_word_i,
  output logic                 valid_o,
  output logic [PC_W-1:0]      next_pc_o,
  output logic                 taken_o,
  output logic [CYC_W-1:0]     cycles_o
);
  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  br_tgt;
  logic [PC_W-1:0]  jmp_tgt;
  logic             flag_hit;
  logic             skip_hit;
  logic [PC_W-1:0]  skip_pc;
  logic [CYC_W-1:0] skip_cyc;
  op_e              op;
  npc_res_t         res_d;
  npc_res_t         res_q;
  logic             valid_q;

  assign op     = op_e'(op_i);
  assign seq_pc = pc_i + PC_W'(1);

  npc_bit_test #(.W(DATA_W)) u_flag (
    .data_i (sreg_i),
    .sel_i  (sel_i),
    .pol_i  (pol_i),
    .hit_o  (flag_hit)
  );

  npc_rel_adder #(.PC_W(PC_W), .OFF_W(BR_OFF_W)) u_br_add (
    .pc_i  (pc_i),
    .off_i (offset_i[BR_OFF_W-1:0]),
    .tgt_o (br_tgt)
  );

  npc_rel_adder #(.PC_W(PC_W), .OFF_W(JMP_OFF_W)) u_jmp_add (
    .pc_i  (pc_i),
    .off_i (offset_i),
    .tgt_o (jmp_tgt)
  );

  npc_skip_eval #(.PC_W(PC_W), .DATA_W(DATA_W), .CYC_W(CYC_W)) u_skip (
    .pc_i       (pc_i),
    .bit_mode_i (op == OP_SKIP_BIT),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .sel_i      (sel_i),
    .pol_i      (pol_i),
    .two_word_i (two_word_i),
    .skip_o     (skip_hit),
    .npc_o      (skip_pc),
    .cycles_o   (skip_cyc)
  );

  always_comb begin
    res_d.npc    = seq_pc;
    res_d.taken  = 1'b0;
    res_d.cycles = CYC_W'(1);
    unique case (op)
      OP_FLAG_BR: begin
        if (flag_hit) begin
          res_d.npc    = br_tgt;
          res_d.taken  = 1'b1;
          res_d.cycles = CYC_W'(2);
        end
      end
      OP_REL_JMP: begin
        res_d.npc    = jmp_tgt;
        res_d.taken  = 1'b1;
        res_d.cycles = CYC_W'(2);
      end
      OP_SKIP_EQ, OP_SKIP_BIT: begin
        res_d.npc    = skip_pc;
        res_d.taken  = skip_hit;
        res_d.cycles = skip_cyc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o   = valid_q;
  assign next_pc_o = res_q.npc;
  assign taken_o   = res_q.taken;
  assign cycles_o  = res_q.cycles;
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker
  import npc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [OP_W-1:0]      op_i,
  input logic [PC_W-1:0]      pc_i,
  input logic [DATA_W-1:0]    opa_i,
  input logic [DATA_W-1:0]    opb_i,
  input logic                 two_word_i,
  input logic                 valid_o,
  input logic [PC_W-1:0]      next_pc_o,
  input logic                 taken_o,
  input logic [CYC_W-1:0]     cycles_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && next_pc_o == '0 && !taken_o && cycles_o == '0));

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(next_pc_o) && $stable(taken_o) && $stable(cycles_o)));

  assert_branch_cycles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 3'd0 && taken_o) |-> cycles_o == 2'd2);

  assert_not_taken_seq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_W'(1) && cycles_o == 2'd1));

  assert_jump_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 3'd1) |-> (taken_o && cycles_o == 2'd2));

  assert_skip_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 3'd2) |-> (taken_o == ($past(opa_i) == $past(opb_i))));

  assert_skip_length_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && ($past(op_i) == 3'd2 || $past(op_i) == 3'd3))
      |-> (cycles_o == ($past(two_word_i) ? 2'd3 : 2'd2)
           && next_pc_o == $past(pc_i) + PC_W'(cycles_o)));

  assert_other_ops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) >= 3'd4) |-> (!taken_o && cycles_o == 2'd1));
endmodule

bind npc_unit npc_unit_checker u_npc_unit_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .pc_i       (pc_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .two_word_i (two_word_i),
  .valid_o    (valid_o),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .cycles_o   (cycles_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  sreg_i = '0;
  logic [2:0]  sel_i = '0;
  logic        pol_i = 1'b0;
  logic [11:0] offset_i = '0;
  logic [7:0]  opa_i = '0;
  logic [7:0]  opb_i = '0;
  logic        two_word_i = 1'b0;
  logic        valid_o;
  logic [15:0] next_pc_o;
  logic        taken_o;
  logic [1:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  npc_unit u_npc_unit (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [15:0] pc;
    logic [7:0]  sreg;
    logic [2:0]  sel;
    logic        pol;
    logic [11:0] off;
    logic [7:0]  a;
    logic [7:0]  b;
    logic        tw;
    logic [15:0] epc;
    logic        etk;
    logic [1:0]  ecy;
  } vec_t;

  localparam int NV = 20;
  // req, op, pc, sreg, sel, pol, off, a, b, tw, exp_pc, exp_taken, exp_cycles
  localparam vec_t TBL [NV] = '{
    '{4'd3,  3'd0, 16'h0100, 8'h02, 3'd1, 1'b1, 12'h005, 8'h00, 8'h00, 1'b0, 16'h0106, 1'b1, 2'd2}, // R3 equal
    '{4'd5,  3'd0, 16'h0100, 8'h02, 3'd1, 1'b0, 12'h005, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 2'd1}, // R5 not-equal
    '{4'd4,  3'd0, 16'h0200, 8'h01, 3'd0, 1'b1, 12'h07E, 8'h00, 8'h00, 1'b0, 16'h01FF, 1'b1, 2'd2}, // R4 lower, back 2
    '{4'd4,  3'd0, 16'h0300, 8'h80, 3'd7, 1'b1, 12'hF85, 8'h00, 8'h00, 1'b0, 16'h0306, 1'b1, 2'd2}, // R4 high offset bits ignored
    '{4'd3,  3'd0, 16'h0010, 8'h10, 3'd4, 1'b0, 12'h005, 8'h00, 8'h00, 1'b0, 16'h0011, 1'b0, 2'd1}, // R3 signed ge with S set
    '{4'd3,  3'd0, 16'h1000, 8'h40, 3'd6, 1'b1, 12'h03F, 8'h00, 8'h00, 1'b0, 16'h1040, 1'b1, 2'd2}, // R3 T set, max forward
    '{4'd4,  3'd0, 16'h1000, 8'h08, 3'd3, 1'b1, 12'h040, 8'h00, 8'h00, 1'b0, 16'h0FC1, 1'b1, 2'd2}, // R4 overflow, -64
    '{4'd6,  3'd1, 16'h0400, 8'h00, 3'd0, 1'b0, 12'h7FF, 8'h00, 8'h00, 1'b0, 16'h0C00, 1'b1, 2'd2}, // R6 +2047
    '{4'd6,  3'd1, 16'h0400, 8'h00, 3'd0, 1'b0, 12'h800, 8'h00, 8'h00, 1'b0, 16'hFC01, 1'b1, 2'd2}, // R6 -2048
    '{4'd10, 3'd1, 16'hFFFF, 8'hFF, 3'd0, 1'b0, 12'h000, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 2'd2}, // R10 jump wrap
    '{4'd10, 3'd0, 16'hFFFE, 8'h04, 3'd2, 1'b1, 12'h001, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 2'd2}, // R10 minus, wrap
    '{4'd7,  3'd2, 16'h0050, 8'h00, 3'd0, 1'b0, 12'h000, 8'h3C, 8'h3C, 1'b0, 16'h0052, 1'b1, 2'd2}, // R7 equal one word
    '{4'd9,  3'd2, 16'h0050, 8'h00, 3'd0, 1'b0, 12'h000, 8'h3C, 8'h3C, 1'b1, 16'h0053, 1'b1, 2'd3}, // R9 equal two words
    '{4'd7,  3'd2, 16'h0050, 8'hFF, 3'd0, 1'b1, 12'h000, 8'h3C, 8'h3D, 1'b1, 16'h0051, 1'b0, 2'd1}, // R7 unequal
    '{4'd8,  3'd3, 16'h0060, 8'h00, 3'd3, 1'b0, 12'h000, 8'hF7, 8'h00, 1'b0, 16'h0062, 1'b1, 2'd2}, // R8 skip if clear
    '{4'd8,  3'd3, 16'h0060, 8'h00, 3'd3, 1'b1, 12'h000, 8'hF7, 8'h00, 1'b0, 16'h0061, 1'b0, 2'd1}, // R8 skip if set, clear
    '{4'd9,  3'd3, 16'hFFFE, 8'h00, 3'd7, 1'b1, 12'h000, 8'h80, 8'h00, 1'b1, 16'h0001, 1'b1, 2'd3}, // R9 two words, wrap
    '{4'd11, 3'd5, 16'h1234, 8'hFF, 3'd0, 1'b1, 12'h010, 8'h11, 8'h11, 1'b1, 16'h1235, 1'b0, 2'd1}, // R11 class 5
    '{4'd11, 3'd7, 16'hFFFF, 8'hFF, 3'd0, 1'b1, 12'h7FF, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 2'd1}, // R11 class 7 wrap
    '{4'd3,  3'd0, 16'h0020, 8'hDF, 3'd5, 1'b1, 12'h010, 8'h00, 8'h00, 1'b0, 16'h0021, 1'b0, 2'd1}  // R3 half carry clear
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = v.op; pc_i = v.pc; sreg_i = v.sreg; sel_i = v.sel;
    pol_i = v.pol; offset_i = v.off; opa_i = v.a; opb_i = v.b; two_word_i = v.tw;
    @(negedge clk_i);
  endtask

  task automatic check_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    check(tag, "valid_o (R2)", int'(valid_o), 1);
    check(tag, "next_pc_o", int'(next_pc_o), int'(v.epc));
    check(tag, "taken_o", int'(taken_o), int'(v.etk));
    check(tag, "cycles_o", int'(cycles_o), int'(v.ecy));
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "valid_o", int'(valid_o), 0);
    check("R1", "next_pc_o", int'(next_pc_o), 0);
    check("R1", "taken_o", int'(taken_o), 0);
    check("R1", "cycles_o", int'(cycles_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check_vec(TBL[i]);
    end

    // R2 hold: drop valid with a stimulus that would change every result
    drive(TBL[2]);
    valid_i = 1'b0; op_i = 3'd1; pc_i = 16'h4444; offset_i = 12'h123;
    @(negedge clk_i);
    check("R2", "valid_o idle", int'(valid_o), 0);
    check("R2", "next_pc_o held", int'(next_pc_o), 16'h01FF);
    check("R2", "taken_o held", int'(taken_o), 1);
    check("R2", "cycles_o held", int'(cycles_o), 2);

    // R9 no skip ignores two_word_i
    drive('{4'd9, 3'd2, 16'h0700, 8'h00, 3'd0, 1'b0, 12'h000, 8'h01, 8'h02, 1'b1,
            16'h0701, 1'b0, 2'd1});
    check("R9", "next_pc_o no skip two words", int'(next_pc_o), 16'h0701);
    check("R9", "cycles_o no skip two words", int'(cycles_o), 1);

    // R8 every bit of operand, skip-if-set on a walking one
    for (int b = 0; b < 8; b++) begin
      drive('{4'd8, 3'd3, 16'h0800, 8'h00, 3'(b), 1'b1, 12'h000, 8'(1 << b), 8'h00,
              1'b0, 16'h0802, 1'b1, 2'd2});
      check("R8", $sformatf("bit %0d set skip", b), int'(taken_o), 1);
    end

    // R3 every status bit, branch-if-clear on a walking zero
    for (int b = 0; b < 8; b++) begin
      drive('{4'd3, 3'd0, 16'h0900, 8'(~(1 << b)), 3'(b), 1'b0, 12'h002, 8'h00, 8'h00,
              1'b0, 16'h0903, 1'b1, 2'd2});
      check("R3", $sformatf("status bit %0d clear", b), int'(next_pc_o), 16'h0903);
    end

    // R1 reset in mid-run clears outputs
    drive(TBL[7]);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    #1;
    check("R1", "next_pc_o after async reset", int'(next_pc_o), 0);
    check("R1", "valid_o after async reset", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule